// File: doc/BRIEF.md
# Dual-Channel Timer Output Compare Unit

This block watches a 16-bit free-running count supplied from outside and compares it with two programmable 16-bit compare values, one per channel. When the count steps onto a channel's compare value, the block raises that channel's match flag. If the channel's output is enabled, it also drives a programmed logic level onto the channel's output pin. The counter, its prescaler, counter clearing and interrupt generation are all outside this block.

Software reaches the unit over an 8-bit bus with four byte addresses. Both compare values sit behind the same pair of addresses, and a select bit in the control byte picks which channel is read or written. A 16-bit value is written as two bytes. The high byte is parked in a staging register, and the low-byte write then moves all 16 bits into the selected compare register in a single cycle, so the comparator never sees a half-updated value. A standby input returns both compare values to all ones.

Top module: `dual_compare_timer`

## Requirements
- R1: After reset both compare registers read 0xFFFF, the control byte reads 0x00, the status byte reads 0x00 and both output pins are 0.
- R2: When the count input changes to a value equal to a channel's compare register, that channel's match flag (status bit 0 for channel A, bit 1 for channel B) reads 1 from the following clock onward.
- R3: On a match with the channel's output enable set, the channel's pin (cmp_pin_o bit 0 for A, bit 1 for B) takes the channel's level bit in the following cycle.
- R4: With the channel's output enable clear, a match leaves the pin at its previous value.
- R5: A match is raised only on a cycle where the count differs from its previous value. A count held equal to the compare value does not set the flag again once it has been cleared.
- R6: Bus address 0 accesses the high byte and address 1 the low byte of the compare register picked by control bit 0 (0 = A, 1 = B). Address 2 is the control byte, which reads back as written: bit 0 select, bits 1/2 output enable A/B, bits 3/4 level A/B. Address 3 is the status byte.
- R7: A write to address 0 changes only the staging byte, and the compare registers are unchanged. A write to address 1 loads {staging byte, written byte} into the currently selected compare register in one cycle.
- R8: A match flag is cleared only by a write with a 0 in its bit after a status read that saw the flag at 1. A 0 written without such a read, or a 1 written, leaves the flag set.
- R9: While standby is high, both compare registers are forced to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Standby request; resets the compare values |
| count_i | input | 16 | Free-running counter value |
| bus_addr_i | input | 2 | Register byte address |
| bus_wr_i | input | 1 | Byte write strobe |
| bus_rd_i | input | 1 | Byte read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational) |
| cmp_pin_o | output | 2 | Compare output pins, bit 0 channel A |

## Verification
The hardest state to reach from the ports is a count that stays equal to a compare value while the flag is cleared. In that state a correct design stays silent, while a level-sensitive one would set the flag again at once. The bench steps the count onto the compare value, clears the flag through the read-then-write sequence while holding the count, waits several cycles and reads status again. A second hard case is a staged high byte that is loaded into a different channel because the select bit was changed between the two byte writes.

// File: rtl/tocu_pkg.sv
package tocu_pkg;

  localparam int DEF_BUS_W = 8;
  localparam int DEF_NCH   = 2;

  typedef enum logic [1:0] {
    RA_CMP_HI = 2'd0,
    RA_CMP_LO = 2'd1,
    RA_CTRL   = 2'd2,
    RA_STAT   = 2'd3
  } reg_addr_e;

endpackage

// File: rtl/tocu_cnt_track.sv
module tocu_cnt_track #(
  parameter int CMP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CMP_W-1:0] cnt_i,
  output logic [CMP_W-1:0] prev_o,
  output logic             valid_o
);

  logic [CMP_W-1:0] prev_q;
  logic             valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      prev_q  <= cnt_i;
      valid_q <= 1'b1;
    end
  end

  assign prev_o  = prev_q;
  assign valid_o = valid_q;

  // R5: history stays valid once established
  p_valid_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);

endmodule

// File: rtl/tocu_bus.sv
module tocu_bus #(
  parameter int BUS_W = 8,
  parameter int NCH   = 2,
  localparam int CMP_W = 2 * BUS_W,
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           addr_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [BUS_W-1:0]     wdata_i,
  input  logic [NCH*CMP_W-1:0] cmp_flat_i,
  input  logic [NCH-1:0]       flag_i,
  output logic [BUS_W-1:0]     rdata_o,
  output logic [NCH-1:0]       oe_o,
  output logic [NCH-1:0]       lvl_o,
  output logic [NCH-1:0]       load_o,
  output logic [CMP_W-1:0]     load_val_o,
  output logic                 st_rd_o,
  output logic                 st_wr_o,
  output logic [NCH-1:0]       st_wbit_o
);
  import tocu_pkg::*;

  logic [BUS_W-1:0] stage_q;
  logic [BUS_W-1:0] ctrl_q;
  logic [SEL_W-1:0] sel;
  logic [CMP_W-1:0] picked;
  logic             hi_wr, lo_wr, ctrl_wr;

  function automatic logic [CMP_W-1:0] pick_cmp(input logic [NCH*CMP_W-1:0] flat,
                                                 input logic [SEL_W-1:0] s);
    return flat[int'(s)*CMP_W +: CMP_W];
  endfunction

  function automatic logic [CMP_W-1:0] join_bytes(input logic [BUS_W-1:0] hi,
                                                   input logic [BUS_W-1:0] lo);
    return {hi, lo};
  endfunction

  assign hi_wr   = wr_i && (addr_i == RA_CMP_HI);
  assign lo_wr   = wr_i && (addr_i == RA_CMP_LO);
  assign ctrl_wr = wr_i && (addr_i == RA_CTRL);
  assign st_wr_o = wr_i && (addr_i == RA_STAT);
  assign st_rd_o = rd_i && (addr_i == RA_STAT);
  assign st_wbit_o = wdata_i[NCH-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (hi_wr)   stage_q <= wdata_i;
      if (ctrl_wr) ctrl_q  <= wdata_i;
    end
  end

  assign sel   = ctrl_q[SEL_W-1:0];
  assign oe_o  = ctrl_q[SEL_W +: NCH];
  assign lvl_o = ctrl_q[SEL_W+NCH +: NCH];

  assign load_val_o = join_bytes(stage_q, wdata_i);

  for (genvar g = 0; g < NCH; g++) begin : g_load
    assign load_o[g] = lo_wr && (int'(sel) == g);
  end

  assign picked = pick_cmp(cmp_flat_i, sel);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_CMP_HI: rdata_o = picked[CMP_W-1:BUS_W];
      RA_CMP_LO: rdata_o = picked[BUS_W-1:0];
      RA_CTRL:   rdata_o = ctrl_q;
      default:   rdata_o[NCH-1:0] = flag_i;
    endcase
  end

  // R7: at most one compare register loads per cycle
  p_load_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_o));

  // R7: staging byte changes only on a high-byte write
  p_stage_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hi_wr |=> $stable(stage_q));

  // R6: control byte changes only on a control write
  p_ctrl_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> $stable(ctrl_q));

endmodule

// File: rtl/tocu_channel.sv
module tocu_channel #(
  parameter int CMP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             standby_i,
  input  logic             load_i,
  input  logic [CMP_W-1:0] load_val_i,
  input  logic [CMP_W-1:0] cnt_i,
  input  logic [CMP_W-1:0] cnt_prev_i,
  input  logic             cnt_valid_i,
  input  logic             oe_i,
  input  logic             lvl_i,
  input  logic             st_rd_i,
  input  logic             st_wr_i,
  input  logic             st_wbit_i,
  output logic [CMP_W-1:0] cmp_o,
  output logic             flag_o,
  output logic             pin_o,
  output logic             hit_o
);

  logic [CMP_W-1:0] cmp_q;
  logic             flag_q, pin_q, armed_q;
  logic             clr;

  // match event: count has just stepped onto the compare value
  function automatic logic step_match(input logic valid,
                                      input logic [CMP_W-1:0] cnt,
                                      input logic [CMP_W-1:0] prev,
                                      input logic [CMP_W-1:0] cmp);
    return valid && (cnt == cmp) && (cnt != prev);
  endfunction

  assign hit_o = step_match(cnt_valid_i, cnt_i, cnt_prev_i, cmp_q);
  assign clr   = st_wr_i && !st_wbit_i && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cmp_q <= '1;
    else if (standby_i) cmp_q <= '1;
    else if (load_i)    cmp_q <= load_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
      pin_q   <= 1'b0;
    end else begin
      if (st_rd_i && flag_q) armed_q <= 1'b1;
      else if (st_wr_i)      armed_q <= 1'b0;

      if (hit_o)    flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;

      if (hit_o && oe_i) pin_q <= lvl_i;
    end
  end

  assign cmp_o  = cmp_q;
  assign flag_o = flag_q;
  assign pin_o  = pin_q;

  // R2: a match sets the flag
  p_flag_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> flag_o);

  // R3: enabled match drives the level bit
  p_pin_drive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && oe_i) |=> (pin_o == $past(lvl_i)));

  // R4: pin holds otherwise
  p_pin_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && oe_i) |=> $stable(pin_o));

  // R5: no match while the count is unchanged
  p_no_retrigger_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == cnt_prev_i) |-> !hit_o);

  // R8: a flag only falls after a status write
  p_clear_by_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(st_wr_i));

  // R9: standby forces all ones
  p_standby_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> (cmp_o == '1));

endmodule

// File: rtl/dual_compare_timer.sv
module dual_compare_timer #(
  parameter int BUS_W = tocu_pkg::DEF_BUS_W,
  parameter int NCH   = tocu_pkg::DEF_NCH,
  localparam int CMP_W = 2 * BUS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             standby_i,
  input  logic [CMP_W-1:0] count_i,
  input  logic [1:0]       bus_addr_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic [BUS_W-1:0] bus_rdata_o,
  output logic [NCH-1:0]   cmp_pin_o
);

  logic [CMP_W-1:0]     cnt_prev;
  logic                 cnt_valid;
  logic [NCH*CMP_W-1:0] cmp_flat;
  logic [NCH-1:0]       flags, oe, lvl, load, st_wbit, hits;
  logic [CMP_W-1:0]     load_val;
  logic                 st_rd, st_wr;

  tocu_cnt_track #(.CMP_W(CMP_W)) u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (count_i),
    .prev_o  (cnt_prev),
    .valid_o (cnt_valid)
  );

  tocu_bus #(.BUS_W(BUS_W), .NCH(NCH)) u_bus (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (bus_addr_i),
    .wr_i       (bus_wr_i),
    .rd_i       (bus_rd_i),
    .wdata_i    (bus_wdata_i),
    .cmp_flat_i (cmp_flat),
    .flag_i     (flags),
    .rdata_o    (bus_rdata_o),
    .oe_o       (oe),
    .lvl_o      (lvl),
    .load_o     (load),
    .load_val_o (load_val),
    .st_rd_o    (st_rd),
    .st_wr_o    (st_wr),
    .st_wbit_o  (st_wbit)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tocu_channel #(.CMP_W(CMP_W)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .standby_i   (standby_i),
      .load_i      (load[g]),
      .load_val_i  (load_val),
      .cnt_i       (count_i),
      .cnt_prev_i  (cnt_prev),
      .cnt_valid_i (cnt_valid),
      .oe_i        (oe[g]),
      .lvl_i       (lvl[g]),
      .st_rd_i     (st_rd),
      .st_wr_i     (st_wr),
      .st_wbit_i   (st_wbit[g]),
      .cmp_o       (cmp_flat[g*CMP_W +: CMP_W]),
      .flag_o      (flags[g]),
      .pin_o       (cmp_pin_o[g]),
      .hit_o       (hits[g])
    );
  end

  // R1: pins are low right after reset release
  p_pins_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_valid |-> (cmp_pin_o == '0));

  // R2: a flag rises only as a result of a match
  p_flag_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[0]) |-> $past(hits[0]));

endmodule

// File: tb/dual_compare_timer_test.sv
module dual_compare_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0;
  logic [15:0] cnt = 16'h0000;
  logic [1:0]  addr = 2'd0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [1:0]  pins;

  int n_tests = 0;
  int n_fail  = 0;

  localparam logic [1:0] A_HI = 2'd0, A_LO = 2'd1, A_CTRL = 2'd2, A_STAT = 2'd3;

  // {channel, output enable, level, compare value}
  localparam logic [18:0] VEC [8] = '{
    {1'b0, 1'b1, 1'b1, 16'h0010},
    {1'b1, 1'b1, 1'b1, 16'h1234},
    {1'b0, 1'b0, 1'b0, 16'h8000},
    {1'b1, 1'b1, 1'b0, 16'h00FF},
    {1'b0, 1'b1, 1'b0, 16'hABCD},
    {1'b1, 1'b0, 1'b1, 16'h7FFF},
    {1'b0, 1'b1, 1'b1, 16'h0001},
    {1'b1, 1'b1, 1'b1, 16'hFFFE}
  };

  // bench-side model
  logic [15:0] cmp_m [2];
  logic [1:0]  oe_m, lvl_m, pin_m;

  always #2 clk = ~clk;

  dual_compare_timer uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .standby_i   (standby),
    .count_i     (cnt),
    .bus_addr_i  (addr),
    .bus_wr_i    (wr_en),
    .bus_rd_i    (rd_en),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .cmp_pin_o   (pins)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_cnt(input logic [15:0] v);
    if (v != cnt)
      for (int c = 0; c < 2; c++)
        if (cmp_m[c] == v && oe_m[c]) pin_m[c] = lvl_m[c];
    cnt = v;
    @(negedge clk);
  endtask

  task automatic write_ctrl(input logic sel);
    bus_wr(A_CTRL, {3'b000, lvl_m[1], lvl_m[0], oe_m[1], oe_m[0], sel});
  endtask

  task automatic program_ch(input logic ch, input logic [15:0] v);
    write_ctrl(ch);
    bus_wr(A_HI, v[15:8]);
    bus_wr(A_LO, v[7:0]);
    cmp_m[ch] = v;
  endtask

  task automatic read_cmp(output logic [15:0] v);
    logic [7:0] h, l;
    bus_rd(A_HI, h);
    bus_rd(A_LO, l);
    v = {h, l};
  endtask

  task automatic clear_flags();
    logic [7:0] d;
    bus_rd(A_STAT, d);
    bus_wr(A_STAT, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] v;
    cmp_m[0] = 16'hFFFF; cmp_m[1] = 16'hFFFF;
    oe_m = 2'b00; lvl_m = 2'b00; pin_m = 2'b00;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 pins", {30'd0, pins}, 32'd0);
    bus_rd(A_CTRL, d); chk("R1 ctrl", {24'd0, d}, 32'h00);
    bus_rd(A_STAT, d); chk("R1 status", {24'd0, d}, 32'h00);
    read_cmp(v); chk("R1 compare A", {16'd0, v}, 32'hFFFF);
    bus_wr(A_CTRL, 8'h01);
    read_cmp(v); chk("R1 compare B", {16'd0, v}, 32'hFFFF);
    bus_wr(A_CTRL, 8'h00);

    // table walk: R2 R3 R4 R6
    for (int i = 0; i < 8; i++) begin
      logic        ch;
      logic [15:0] cv;
      ch = VEC[i][18];
      oe_m[ch]  = VEC[i][17];
      lvl_m[ch] = VEC[i][16];
      cv = VEC[i][15:0];
      set_cnt(cv - 16'd2);
      set_cnt(cv - 16'd1);
      program_ch(ch, cv);
      read_cmp(v); chk("R6 selected readback", {16'd0, v}, {16'd0, cv});
      clear_flags();
      bus_rd(A_STAT, d); chk("R2 flag before match", {31'd0, d[ch]}, 32'd0);
      set_cnt(cv);
      chk("R3/R4 pins after match", {30'd0, pins}, {30'd0, pin_m});
      bus_rd(A_STAT, d); chk("R2 flag after match", {31'd0, d[ch]}, 32'd1);
      set_cnt(cv + 16'd1);
    end

    // R5: held equality does not re-trigger
    oe_m[0] = 1'b1; lvl_m[0] = 1'b1;
    program_ch(1'b0, 16'h0500);
    set_cnt(16'h04FF);
    set_cnt(16'h0500);
    clear_flags();
    repeat (5) @(negedge clk);
    bus_rd(A_STAT, d); chk("R5 no retrigger while equal", {31'd0, d[0]}, 32'd0);
    chk("R5 pins", {30'd0, pins}, {30'd0, pin_m});

    // R8: clear protocol
    set_cnt(16'h0501);
    set_cnt(16'h0500);
    bus_wr(A_STAT, 8'h00);
    bus_rd(A_STAT, d); chk("R8 write 0 without read keeps flag", {31'd0, d[0]}, 32'd1);
    bus_wr(A_STAT, 8'hFF);
    bus_rd(A_STAT, d); chk("R8 write 1 keeps flag", {31'd0, d[0]}, 32'd1);
    bus_wr(A_STAT, 8'h00);
    bus_rd(A_STAT, d); chk("R8 read then write 0 clears", {31'd0, d[0]}, 32'd0);

    // R7: staging
    bus_wr(A_HI, 8'h3C);
    read_cmp(v); chk("R7 high byte alone no load", {16'd0, v}, 32'h0500);
    bus_wr(A_LO, 8'h5A);
    read_cmp(v); chk("R7 low byte loads word", {16'd0, v}, 32'h3C5A);
    cmp_m[0] = 16'h3C5A;
    bus_wr(A_HI, 8'h11);
    write_ctrl(1'b1);
    bus_wr(A_LO, 8'h22);
    cmp_m[1] = 16'h1122;
    read_cmp(v); chk("R7 staged into B after select change", {16'd0, v}, 32'h1122);
    write_ctrl(1'b0);
    read_cmp(v); chk("R6 A untouched by B load", {16'd0, v}, 32'h3C5A);

    // R6: control byte readback
    bus_wr(A_CTRL, 8'hE1);
    oe_m = 2'b00; lvl_m = 2'b00;
    bus_rd(A_CTRL, d); chk("R6 ctrl readback", {24'd0, d}, 32'hE1);

    // R9: standby
    @(negedge clk); standby = 1'b1;
    @(negedge clk); standby = 1'b0;
    cmp_m[0] = 16'hFFFF; cmp_m[1] = 16'hFFFF;
    read_cmp(v); chk("R9 standby B", {16'd0, v}, 32'hFFFF);
    bus_wr(A_CTRL, 8'h00);
    read_cmp(v); chk("R9 standby A", {16'd0, v}, 32'hFFFF);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule